// File: doc/BRIEF.md
# Indirect Register Access Bus Sequencer

This block sits on the host side of a peripheral that has only two ports on its external bus: an address port that takes a register index, and a 16-bit data port. A single request is turned into the full set of bus cycles. The block first writes the register index to the address port, then runs one or two data-port cycles. Bit 7 of the written index byte tells the peripheral whether the data cycles that follow are writes or reads. A 32-bit value is moved as two 16-bit halves, low half first.

The peripheral needs a minimum quiet time after the address cycle and a shorter minimum quiet time between data cycles. Both times are given in nanoseconds and are converted to clock cycles from the clock period parameter. The strobes stay inactive for the whole of each quiet time. A requester hands over one access through a valid/ready handshake and waits for the done pulse. For reads, the assembled data is valid during that pulse.

Top module: `regbus_seq`

## Requirements
- R1: Every access begins with one write strobe (busWeN low) on the address port (busSelAddr = 1). The byte driven on busDout[7:0] is {reqWrite, reqIdx[6:0]}, with bit 7 set for writes and clear for reads. busDout[15:8] is zero.
- R2: A 16-bit write (reqWide = 0) produces exactly one data-port write strobe (busSelAddr = 0), carrying reqWdata[15:0].
- R3: A 32-bit access (reqWide = 1) produces exactly two data-port strobes. The first carries bits 15:0 and the second carries bits 31:16, on both writes and reads.
- R4: On a read, the data cycles use busOeN. busDin is sampled on the last cycle of each OE strobe into rdData[15:0] (first cycle) and rdData[31:16] (second cycle). A 16-bit read returns zero in rdData[31:16].
- R5: Between the end of the address strobe and the start of the first data strobe, both strobes stay inactive for exactly ceil(ADDR_GAP_NS / CLK_NS) cycles.
- R6: Between the two data strobes of a 32-bit access, both strobes stay inactive for exactly ceil(DATA_GAP_NS / CLK_NS) cycles.
- R7: Each strobe stays active for exactly STROBE_CYC consecutive cycles. busOeN and busWeN are never active together.
- R8: reqReady is high only while busy is low. A request is taken when reqValid and reqReady are both high. Requests offered while busy have no effect. done is a one-cycle pulse, and busy is low in the cycle after it.
- R9: busDoe is high exactly in the cycles in which busWeN is low, so the data bus is released during read strobes and gaps.
- R10: After reset, busCsN, busOeN and busWeN are high, busDoe and busy are low, and reqReady is high.
- R11: busCsN is low from the first strobe of an access through its last strobe, including the gaps, and high whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer can take a request |
| reqWrite | input | 1 | 1 = register write, 0 = register read |
| reqWide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| reqIdx | input | 7 | Register index |
| reqWdata | input | 32 | Write value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Read result, valid with done |
| busCsN | output | 1 | Chip select, active low |
| busSelAddr | output | 1 | 1 = address port, 0 = data port |
| busOeN | output | 1 | Read strobe, active low |
| busWeN | output | 1 | Write strobe, active low |
| busDout | output | 16 | Data driven onto the bus |
| busDoe | output | 1 | Bus output enable |
| busDin | input | 16 | Data read from the bus |

## Verification
A wrong state or counter value changes where the next strobe edge falls. The bench times every strobe edge, so the error shows within one access: as a gap or strobe length off by a cycle, or as a missing or extra data strobe. A wrong half flag swaps the two 16-bit halves. This shows up in the first 32-bit access, either in the data observed on the bus or in the assembled read result at done. A lost or extra FIN state shows as a missing done pulse, which the bench catches with a timeout, or as a busy signal that outlasts done.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AGAP,
    ST_DATA,
    ST_DGAP,
    ST_FIN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic driveAddr;
    logic driveHi;
    logic captureLo;
    logic captureHi;
  } dpCtrl_t;

endpackage

// File: rtl/regbus_dp.sv
module regbus_dp
  import regbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               ctl,
  input  logic                  reqWrite,
  input  logic                  reqWide,
  input  logic [IDX_W-1:0]      reqIdx,
  input  logic [2*DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]     busDin,
  output logic [DATA_W-1:0]     busDout,
  output logic [2*DATA_W-1:0]   rdData,
  output logic                  wrFlag,
  output logic                  wideFlag
);

  localparam int PAD_W = DATA_W - IDX_W - 1;

  logic [IDX_W-1:0]    idxQ;
  logic [2*DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ     <= '0;
      wdataQ   <= '0;
      wrFlag   <= 1'b0;
      wideFlag <= 1'b0;
      rdData   <= '0;
    end else begin
      if (ctl.loadReq) begin
        idxQ     <= reqIdx;
        wdataQ   <= reqWdata;
        wrFlag   <= reqWrite;
        wideFlag <= reqWide;
        rdData   <= '0;
      end
      if (ctl.captureLo) rdData[DATA_W-1:0]        <= busDin;
      if (ctl.captureHi) rdData[2*DATA_W-1:DATA_W] <= busDin;
    end
  end

  always_comb begin
    if (ctl.driveAddr)    busDout = {{PAD_W{1'b0}}, wrFlag, idxQ};
    else if (ctl.driveHi) busDout = wdataQ[2*DATA_W-1:DATA_W];
    else                  busDout = wdataQ[DATA_W-1:0];
  end

  // R1: the address byte is held steady for the whole address phase
  a_r1_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.driveAddr && $past(ctl.driveAddr)) |-> $stable(busDout));

  // R4: data is captured only in a read access
  a_r4_capture_read: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.captureLo || ctl.captureHi) |-> !wrFlag);

endmodule

// File: rtl/regbus_ctrl.sv
module regbus_ctrl
  import regbus_pkg::*;
#(
  parameter int STROBE_CYC   = 3,
  parameter int ADDR_GAP_CYC = 15,
  parameter int DATA_GAP_CYC = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    wrFlag,
  input  logic    wideFlag,
  output logic    reqReady,
  output logic    busy,
  output logic    done,
  output dpCtrl_t ctl,
  output logic    busCsN,
  output logic    busSelAddr,
  output logic    busOeN,
  output logic    busWeN,
  output logic    busDoe
);

  localparam int MAX_A = (STROBE_CYC > ADDR_GAP_CYC) ? STROBE_CYC : ADDR_GAP_CYC;
  localparam int MAX_C = (MAX_A > DATA_GAP_CYC) ? MAX_A : DATA_GAP_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] STB_LOAD  = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] AGAP_LOAD = CNT_W'(ADDR_GAP_CYC - 1);
  localparam logic [CNT_W-1:0] DGAP_LOAD = CNT_W'(DATA_GAP_CYC - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             half;
  logic             lastCyc;

  assign lastCyc = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      half  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_ADDR;
          cnt   <= STB_LOAD;
          half  <= 1'b0;
        end
        ST_ADDR:
          if (lastCyc) begin state <= ST_AGAP; cnt <= AGAP_LOAD; end
          else cnt <= cnt - 1'b1;
        ST_AGAP:
          if (lastCyc) begin state <= ST_DATA; cnt <= STB_LOAD; end
          else cnt <= cnt - 1'b1;
        ST_DATA:
          if (lastCyc) begin
            if (wideFlag && !half) begin state <= ST_DGAP; cnt <= DGAP_LOAD; end
            else state <= ST_FIN;
          end else cnt <= cnt - 1'b1;
        ST_DGAP:
          if (lastCyc) begin state <= ST_DATA; cnt <= STB_LOAD; half <= 1'b1; end
          else cnt <= cnt - 1'b1;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (state != ST_IDLE);
    reqReady   = !busy;
    done       = (state == ST_FIN);
    busCsN     = !(state inside {ST_ADDR, ST_AGAP, ST_DATA, ST_DGAP});
    busSelAddr = (state == ST_ADDR) || (state == ST_AGAP);
    busWeN     = !((state == ST_ADDR) || (state == ST_DATA && wrFlag));
    busOeN     = !(state == ST_DATA && !wrFlag);
    busDoe     = (state == ST_ADDR) || (state == ST_DATA && wrFlag);
    ctl.loadReq   = (state == ST_IDLE) && reqValid;
    ctl.driveAddr = busSelAddr;
    ctl.driveHi   = half;
    ctl.captureLo = (state == ST_DATA) && lastCyc && !wrFlag && !half;
    ctl.captureHi = (state == ST_DATA) && lastCyc && !wrFlag && half;
  end

  // R8: done lasts one cycle and leaves the block idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R7: read and write strobes never overlap
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!busOeN && !busWeN));

  // R3: a second data half only follows a wide request
  a_r3_half_wide: assert property (@(posedge clk) disable iff (!rstN)
    (half && state == ST_DATA) |-> wideFlag);

endmodule

// File: rtl/regbus_seq.sv
module regbus_seq
  import regbus_pkg::*;
#(
  parameter int CLK_NS      = 20,
  parameter int ADDR_GAP_NS = 300,
  parameter int DATA_GAP_NS = 150,
  parameter int STROBE_CYC  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic        reqWide,
  input  logic [6:0]  reqIdx,
  input  logic [31:0] reqWdata,
  output logic        busy,
  output logic        done,
  output logic [31:0] rdData,
  output logic        busCsN,
  output logic        busSelAddr,
  output logic        busOeN,
  output logic        busWeN,
  output logic [15:0] busDout,
  output logic        busDoe,
  input  logic [15:0] busDin
);

  localparam int ADDR_GAP_CYC = (ADDR_GAP_NS + CLK_NS - 1) / CLK_NS;
  localparam int DATA_GAP_CYC = (DATA_GAP_NS + CLK_NS - 1) / CLK_NS;

  dpCtrl_t ctl;
  logic    wrFlag;
  logic    wideFlag;

  regbus_ctrl #(
    .STROBE_CYC  (STROBE_CYC),
    .ADDR_GAP_CYC(ADDR_GAP_CYC),
    .DATA_GAP_CYC(DATA_GAP_CYC)
  ) uCtrl (
    .clk, .rstN, .reqValid, .wrFlag, .wideFlag,
    .reqReady, .busy, .done, .ctl,
    .busCsN, .busSelAddr, .busOeN, .busWeN, .busDoe
  );

  regbus_dp #(.DATA_W(16), .IDX_W(7)) uDp (
    .clk, .rstN, .ctl, .reqWrite, .reqWide, .reqIdx, .reqWdata,
    .busDin, .busDout, .rdData, .wrFlag, .wideFlag
  );

  // gap watcher across the two submodules
  localparam int QUIET_MAX = (ADDR_GAP_CYC > DATA_GAP_CYC) ? ADDR_GAP_CYC : DATA_GAP_CYC;
  localparam int QUIET_W   = $clog2(QUIET_MAX + 2);

  logic               strobeOn;
  logic               prevOn;
  logic               lastWasAddr;
  logic [QUIET_W-1:0] quiet;

  assign strobeOn = !busOeN || !busWeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOn      <= 1'b0;
      lastWasAddr <= 1'b0;
      quiet       <= '0;
    end else begin
      prevOn <= strobeOn;
      if (strobeOn) begin
        quiet       <= '0;
        lastWasAddr <= busSelAddr;
      end else if (quiet != QUIET_W'(QUIET_MAX + 1)) begin
        quiet <= quiet + 1'b1;
      end
    end
  end

  // R5: quiet time after the address strobe
  a_r5_addr_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOn && !prevOn && !busSelAddr && lastWasAddr)
      |-> (quiet >= QUIET_W'(ADDR_GAP_CYC)));

  // R6: quiet time between data strobes
  a_r6_data_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOn && !prevOn && !busSelAddr && !lastWasAddr)
      |-> (quiet >= QUIET_W'(DATA_GAP_CYC)));

  // R11: chip select covers every strobe
  a_r11_cs_cover: assert property (@(posedge clk) disable iff (!rstN)
    strobeOn |-> !busCsN);

  // R9: bus driven exactly while writing
  a_r9_doe_we: assert property (@(posedge clk) disable iff (!rstN)
    busDoe == !busWeN);

  // R2: write data steady during a data write strobe
  a_r2_dout_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!busWeN && $past(!busWeN) && !busSelAddr) |-> $stable(busDout));

endmodule

// File: tb/sim_regbus_seq.sv
module sim_regbus_seq;

  localparam int S  = 3;   // strobe length
  localparam int AG = 15;  // ceil(300/20)
  localparam int DG = 8;   // ceil(150/20)

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqWide = 1'b0;
  logic [6:0]  reqIdx = '0;
  logic [31:0] reqWdata = '0;
  logic [15:0] busDin;
  logic        reqReady, busy, done, busCsN, busSelAddr, busOeN, busWeN, busDoe;
  logic [31:0] rdData;
  logic [15:0] busDout;

  always #10 clk = ~clk;

  regbus_seq #(.CLK_NS(20), .ADDR_GAP_NS(300), .DATA_GAP_NS(150), .STROBE_CYC(S)) u0 (
    .clk, .rstN, .reqValid, .reqReady, .reqWrite, .reqWide, .reqIdx, .reqWdata,
    .busy, .done, .rdData, .busCsN, .busSelAddr, .busOeN, .busWeN, .busDout,
    .busDoe, .busDin
  );

  int checks = 0;
  int errors = 0;

  // bus monitor and peripheral model
  int          cyc = 0;
  int          evN = 0;
  int          evKind [0:7];  // 2 addr, 1 data write, 0 data read
  logic [15:0] evVal  [0:7];
  int          evStart[0:7];
  int          evLen  [0:7];
  int          doeBad = 0, bothBad = 0, csBad = 0;
  logic        prevAct = 1'b0, prevOe = 1'b0;
  logic [7:0]  lastAddr = '0, rdCnt = '0;

  assign busDin = {lastAddr, rdCnt};

  always @(negedge clk) begin
    logic act;
    act = !busOeN || !busWeN;
    if (rstN) begin
      if (act && !prevAct && evN < 8) begin
        evKind[evN]  = !busWeN ? (busSelAddr ? 2 : 1) : 0;
        evVal[evN]   = busDout;
        evStart[evN] = cyc;
        evLen[evN]   = 1;
        if (busSelAddr && !busWeN) begin
          lastAddr = busDout[7:0];
          rdCnt    = '0;
        end
        evN++;
      end else if (act && evN > 0) begin
        evLen[evN-1]++;
      end
      if (!act && prevAct && prevOe) rdCnt++;
      if (busDoe != !busWeN) doeBad++;
      if (!busOeN && !busWeN) bothBad++;
      if ((act && busCsN) || (!busy && !busCsN)) csBad++;
    end
    prevAct = act;
    prevOe  = !busOeN;
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] gotRd;
  int          readyBad;

  task automatic runReq(input bit wr, input bit wide, input logic [6:0] idx,
                        input logic [31:0] wd, input bit hold);
    int t;
    @(negedge clk);
    evN = 0; doeBad = 0; bothBad = 0; csBad = 0; readyBad = 0;
    reqWrite = wr; reqWide = wide; reqIdx = idx; reqWdata = wd; reqValid = 1'b1;
    @(negedge clk);
    if (hold) begin
      reqWrite = !wr; reqWide = 1'b0; reqIdx = idx ^ 7'h55; reqWdata = ~wd;
    end else reqValid = 1'b0;
    t = 0;
    while (!done && t < 200) begin
      if (reqReady || !busy) readyBad++;
      @(negedge clk);
      t++;
    end
    chk(done, "R8 done seen", {31'b0, done}, 32'd1);
    gotRd = rdData;
    reqValid = 1'b0;
    @(negedge clk);
    chk(!done && !busy, "R8 pulse end", {30'b0, done, busy}, 32'd0);
  endtask

  task automatic verifySeq(input bit wr, input bit wide, input logic [6:0] idx,
                           input logic [31:0] wd, input string nm);
    int nExp;
    nExp = wide ? 3 : 2;
    chk(evN == nExp, {"R2/R3 strobe count ", nm}, evN, nExp);
    if (evN >= 2) begin
      chk(evKind[0] == 2, {"R1 addr kind ", nm}, evKind[0], 2);
      chk(evVal[0] == {8'h00, wr, idx}, {"R1 addr byte ", nm}, evVal[0], {8'h00, wr, idx});
      chk(evLen[0] == S, {"R7 addr len ", nm}, evLen[0], S);
      chk(evKind[1] == (wr ? 1 : 0), {"R4 data kind ", nm}, evKind[1], wr ? 1 : 0);
      chk(evStart[1] - (evStart[0] + evLen[0]) == AG, {"R5 addr gap ", nm},
          evStart[1] - (evStart[0] + evLen[0]), AG);
      chk(evLen[1] == S, {"R7 data len ", nm}, evLen[1], S);
      if (wr) chk(evVal[1] == wd[15:0], {"R2 low half ", nm}, evVal[1], wd[15:0]);
    end
    if (wide && evN >= 3) begin
      chk(evStart[2] - (evStart[1] + evLen[1]) == DG, {"R6 data gap ", nm},
          evStart[2] - (evStart[1] + evLen[1]), DG);
      chk(evLen[2] == S, {"R7 data2 len ", nm}, evLen[2], S);
      if (wr) chk(evVal[2] == wd[31:16], {"R3 high half ", nm}, evVal[2], wd[31:16]);
    end
    chk(doeBad == 0, {"R9 doe ", nm}, doeBad, 0);
    chk(bothBad == 0, {"R7 overlap ", nm}, bothBad, 0);
    chk(csBad == 0, {"R11 cs ", nm}, csBad, 0);
    chk(readyBad == 0, {"R8 ready while busy ", nm}, readyBad, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(busCsN && busOeN && busWeN, "R10 strobes idle", {29'b0, busCsN, busOeN, busWeN}, 32'h7);
    chk(!busDoe && !busy && reqReady, "R10 handshake", {29'b0, busDoe, busy, reqReady}, 32'h1);
  endtask

  task automatic testWrite16();
    runReq(1'b1, 1'b0, 7'h15, 32'h1234_BEEF, 1'b0);
    verifySeq(1'b1, 1'b0, 7'h15, 32'h1234_BEEF, "w16");
  endtask

  task automatic testWrite32();
    runReq(1'b1, 1'b1, 7'h22, 32'hCAFE_5A5A, 1'b0);
    verifySeq(1'b1, 1'b1, 7'h22, 32'hCAFE_5A5A, "w32");
  endtask

  task automatic testRead16();
    runReq(1'b0, 1'b0, 7'h0F, 32'h0, 1'b0);
    verifySeq(1'b0, 1'b0, 7'h0F, 32'h0, "r16");
    chk(gotRd == 32'h0000_0F00, "R4 read16 data", gotRd, 32'h0000_0F00);
  endtask

  task automatic testRead32();
    runReq(1'b0, 1'b1, 7'h7F, 32'h0, 1'b0);
    verifySeq(1'b0, 1'b1, 7'h7F, 32'h0, "r32");
    chk(gotRd == 32'h7F01_7F00, "R3 R4 read32 order", gotRd, 32'h7F01_7F00);
  endtask

  task automatic testBusyHold();
    // R8: a second request held during the access is not taken
    runReq(1'b1, 1'b1, 7'h33, 32'h0F0F_A5A5, 1'b1);
    verifySeq(1'b1, 1'b1, 7'h33, 32'h0F0F_A5A5, "hold");
    repeat (4) @(negedge clk);
    chk(!busy && busCsN && evN == 3, "R8 no extra access", evN, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWrite16();
    testWrite32();
    testRead16();
    testRead32();
    testBusyHold();
    runReq(1'b0, 1'b0, 7'h00, 32'h0, 1'b0);
    verifySeq(1'b0, 1'b0, 7'h00, 32'h0, "r16 idx0");
    chk(gotRd == 32'h0000_0000, "R4 read idx0", gotRd, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule